// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is a synchronous SPI master that moves one frame at a time. A word taken on a valid/ready input side is shifted out most significant bit first on the serial data output. A frame of the same length is captured from the serial data input at the same time, and the block generates the serial clock and an active-low chip select. The frame length is chosen at run time, from 4 up to the word width.

Inputs that stay static between frames set the timing: the idle level of the serial clock, the phase, and a late-sample option. The late-sample option moves the receive sampling point a fixed number of system clocks past the clock edge, which gives a slow peripheral more setup time. A continuous-select flag keeps chip select low between frames. A 2-bit code sets how long chip select stays low after the last clock edge. The received word leaves the block right-aligned, with a single-cycle valid pulse.

Top module: `spi_shift_master`

## Requirements
- R1: `sclk` rests at `cfg_cpol` while the block is idle. A frame of N bits produces exactly 2N toggles of `sclk`. The first toggle comes CLK_DIV/2 system clocks after the cycle in which the word is accepted, and each later toggle comes CLK_DIV/2 system clocks after the one before.
- R2: With `cfg_cpha` = 0, `mosi` carries the most significant frame bit (bit N-1 of `tx_data`) from the cycle after acceptance, which is before the first clock edge. The next bit follows on each even-numbered toggle (2nd, 4th, ...) of `sclk`.
- R3: With `cfg_cpha` = 1, `mosi` moves to the next bit on each odd-numbered toggle of `sclk` after the first, so each bit is launched on the leading edge of its clock period.
- R4: With `cfg_late_sample` = 0, `miso` is sampled in the system clock in which the capture edge of `sclk` is produced. The capture edge is the leading edge when phase is 0 and the trailing edge when phase is 1.
- R5: With `cfg_late_sample` = 1, `miso` is sampled exactly SAMPLE_LAG system clocks after that capture edge.
- R6: `frame_len` (4 to MAX_BITS) is latched at acceptance. The received bits come back right-aligned in `rx_data`: the first received bit lands at bit N-1, and all bits above N-1 are zero.
- R7: `rx_valid` is high for exactly one cycle per frame, in the cycle after the last bit is sampled.
- R8: `cs_n` falls in the cycle after acceptance and stays low until D system clocks after the last `sclk` toggle. D is set by `cfg_delay_code`: 00 gives 1, 01 gives 3, 10 gives 5 and 11 gives 7.
- R9: `busy` is high, and `tx_ready` low, from the cycle after acceptance until the delay of R8 has run out. While `busy` is high, `tx_valid` and `tx_data` have no effect on the frame in progress.
- R10: If `cfg_hold_cs` is 1 when the delay runs out, `cs_n` stays low while the block is idle, and the next frame starts with no high pulse on `cs_n`. Clearing `cfg_hold_cs` while idle raises `cs_n` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Phase: 0 launches data before the first edge, 1 launches it on the first edge |
| cfg_late_sample | input | 1 | Delays the receive sample by SAMPLE_LAG system clocks |
| cfg_hold_cs | input | 1 | Keeps chip select low between frames |
| cfg_delay_code | input | 2 | Post-transfer delay code (1, 3, 5 or 7 clocks) |
| frame_len | input | $clog2(MAX_BITS+1) | Bits per frame, 4 to MAX_BITS |
| tx_valid | input | 1 | A word is offered to start a frame |
| tx_ready | output | 1 | The block can accept a word |
| tx_data | input | MAX_BITS | Transmit word, right-aligned |
| rx_valid | output | 1 | One-cycle pulse: rx_data holds a new word |
| rx_data | output | MAX_BITS | Received word, right-aligned |
| busy | output | 1 | A frame or its trailing delay is in progress |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |

## Verification
The bench builds the block with CLK_DIV = 6 (half period of 3 clocks), MAX_BITS = 16 and SAMPLE_LAG = 2. The odd half period keeps edge counts, launch points and capture points on different cycles, so an off-by-one in the toggle counter is caught. A lag of 2 opens a window in which the bench's model peripheral drives the true bit only after the capture edge. In that window classic sampling returns the inverted word and late sampling returns the true one, which tells R4 from R5. A 16-bit word width lets frames of both 4 and 16 bits run, and every delay code is used at least once.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_RUN  = 2'd1,
        XS_TAIL = 2'd2
    } xfer_state_e;

    typedef struct packed {
        logic       cpol;
        logic       cpha;
        logic       late;
        logic [1:0] dcode;
    } frame_cfg_t;

    localparam int DLY_W = 3;

    // code c gives 2c+1 system clocks: 1, 3, 5, 7
    function automatic logic [DLY_W-1:0] post_delay_len(input logic [1:0] code);
        return {code, 1'b1};
    endfunction

endpackage

// File: rtl/spi_edge_gen.sv
module spi_edge_gen #(
    parameter  int CLK_DIV  = 4,
    parameter  int MAX_BITS = 16,
    localparam int HALF     = CLK_DIV / 2,
    localparam int HC_W     = (HALF > 1) ? $clog2(HALF) : 1,
    localparam int LEN_W    = $clog2(MAX_BITS + 1),
    localparam int EI_W     = LEN_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             run,
    input  logic             cpol,
    input  logic [LEN_W-1:0] nbits,
    output logic             sclk,
    output logic             edge_stb,
    output logic [EI_W-1:0]  edge_idx,
    output logic             last_edge
);

    logic [HC_W-1:0] hc;
    logic [EI_W-1:0] last_idx;

    assign edge_stb  = run && (hc == HC_W'(HALF - 1));
    assign last_idx  = {nbits, 1'b0} - EI_W'(1);
    assign last_edge = edge_stb && (edge_idx == last_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            hc       <= '0;
            edge_idx <= '0;
            sclk     <= 1'b0;
        end else if (start) begin
            hc       <= '0;
            edge_idx <= '0;
            sclk     <= cpol;
        end else if (run) begin
            if (edge_stb) begin
                hc       <= '0;
                edge_idx <= edge_idx + EI_W'(1);
                sclk     <= ~sclk;
            end else begin
                hc <= hc + HC_W'(1);
            end
        end else begin
            hc   <= '0;
            sclk <= cpol;
        end
    end

    // an edge is never produced past the 2N-th toggle
    p_edge_bound_r1: assert property (@(posedge clk) disable iff (rst)
        edge_stb |-> (edge_idx < {nbits, 1'b0}));

endmodule

// File: rtl/spi_rx_sampler.sv
module spi_rx_sampler #(
    parameter  int MAX_BITS   = 16,
    parameter  int SAMPLE_LAG = 1,
    localparam int LC_W       = (SAMPLE_LAG > 1) ? $clog2(SAMPLE_LAG) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                strobe,
    input  logic                last,
    input  logic                late,
    input  logic                miso,
    output logic                rx_valid,
    output logic [MAX_BITS-1:0] rx_data
);

    logic                pend;
    logic                pend_last;
    logic [LC_W-1:0]     lcnt;
    logic [MAX_BITS-1:0] sh;
    logic                cap;
    logic                cap_last;

    always_comb begin
        if (late) begin
            cap      = pend && (lcnt == '0);
            cap_last = pend_last;
        end else begin
            cap      = strobe;
            cap_last = last;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= 1'b0;
            pend_last <= 1'b0;
            lcnt      <= '0;
            sh        <= '0;
            rx_valid  <= 1'b0;
            rx_data   <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (cap) begin
                if (cap_last) begin
                    rx_data  <= {sh[MAX_BITS-2:0], miso};
                    sh       <= '0;
                    rx_valid <= 1'b1;
                end else begin
                    sh <= {sh[MAX_BITS-2:0], miso};
                end
            end
            if (strobe && late) begin
                pend      <= 1'b1;
                pend_last <= last;
                lcnt      <= LC_W'(SAMPLE_LAG - 1);
            end else if (pend) begin
                if (lcnt == '0) pend <= 1'b0;
                else            lcnt <= lcnt - LC_W'(1);
            end
        end
    end

    // a late sample always completes before the next capture edge arrives
    p_no_overlap_r5: assert property (@(posedge clk) disable iff (rst)
        (strobe && late) |-> !pend);

endmodule

// File: rtl/spi_post_delay.sv
module spi_post_delay
    import spi_xfer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       run,
    input  logic [1:0] code,
    output logic       done
);

    logic [DLY_W-1:0] cnt;

    assign done = run && (cnt == DLY_W'(1));

    always_ff @(posedge clk) begin
        if (rst)                      cnt <= '0;
        else if (load)                cnt <= post_delay_len(code);
        else if (run && cnt != '0)    cnt <= cnt - DLY_W'(1);
    end

    // the trailing window is always loaded before it is counted down
    p_delay_live_r8: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt != '0));

endmodule

// File: rtl/spi_shift_master.sv
module spi_shift_master
    import spi_xfer_pkg::*;
#(
    parameter  int CLK_DIV    = 4,
    parameter  int MAX_BITS   = 16,
    parameter  int SAMPLE_LAG = 1,
    localparam int LEN_W      = $clog2(MAX_BITS + 1),
    localparam int EI_W       = LEN_W + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_cpol,
    input  logic                cfg_cpha,
    input  logic                cfg_late_sample,
    input  logic                cfg_hold_cs,
    input  logic [1:0]          cfg_delay_code,
    input  logic [LEN_W-1:0]    frame_len,
    input  logic                tx_valid,
    output logic                tx_ready,
    input  logic [MAX_BITS-1:0] tx_data,
    output logic                rx_valid,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                busy,
    output logic                sclk,
    output logic                mosi,
    input  logic                miso,
    output logic                cs_n
);

    xfer_state_e         state;
    frame_cfg_t          cfg_q;
    logic [LEN_W-1:0]    nbits_q;
    logic [MAX_BITS-1:0] tx_sh;
    logic                accept;
    logic                run;
    logic                cpol_sel;
    logic                edge_stb;
    logic                last_edge;
    logic [EI_W-1:0]     edge_idx;
    logic                shift_en;
    logic                samp_stb;
    logic                samp_last;
    logic                dly_done;
    logic [LEN_W-1:0]    shamt;

    assign accept    = (state == XS_IDLE) && tx_valid;
    assign run       = (state == XS_RUN);
    assign cpol_sel  = (state == XS_IDLE) ? cfg_cpol : cfg_q.cpol;
    assign shamt     = LEN_W'(MAX_BITS) - frame_len;
    assign tx_ready  = (state == XS_IDLE);
    assign busy      = (state != XS_IDLE);
    assign mosi      = tx_sh[MAX_BITS-1];

    // launch edges: trailing for phase 0, leading (except the first) for phase 1
    assign shift_en  = edge_stb && !last_edge && (edge_idx != '0) &&
                       (edge_idx[0] != cfg_q.cpha);
    // capture edges: leading for phase 0, trailing for phase 1
    assign samp_stb  = edge_stb && (edge_idx[0] == cfg_q.cpha);
    assign samp_last = (edge_idx[EI_W-1:1] == (nbits_q - LEN_W'(1)));

    spi_edge_gen #(
        .CLK_DIV  (CLK_DIV),
        .MAX_BITS (MAX_BITS)
    ) edge_i (
        .clk       (clk),
        .rst       (rst),
        .start     (accept),
        .run       (run),
        .cpol      (cpol_sel),
        .nbits     (nbits_q),
        .sclk      (sclk),
        .edge_stb  (edge_stb),
        .edge_idx  (edge_idx),
        .last_edge (last_edge)
    );

    spi_rx_sampler #(
        .MAX_BITS   (MAX_BITS),
        .SAMPLE_LAG (SAMPLE_LAG)
    ) samp_i (
        .clk      (clk),
        .rst      (rst),
        .strobe   (samp_stb),
        .last     (samp_last),
        .late     (cfg_q.late),
        .miso     (miso),
        .rx_valid (rx_valid),
        .rx_data  (rx_data)
    );

    spi_post_delay dly_i (
        .clk  (clk),
        .rst  (rst),
        .load (last_edge),
        .run  (state == XS_TAIL),
        .code (cfg_q.dcode),
        .done (dly_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= XS_IDLE;
            cs_n    <= 1'b1;
            cfg_q   <= '0;
            nbits_q <= LEN_W'(MAX_BITS);
            tx_sh   <= '0;
        end else begin
            unique case (state)
                XS_IDLE: begin
                    if (tx_valid) begin
                        state   <= XS_RUN;
                        cs_n    <= 1'b0;
                        cfg_q   <= '{cpol: cfg_cpol, cpha: cfg_cpha,
                                     late: cfg_late_sample, dcode: cfg_delay_code};
                        nbits_q <= frame_len;
                        tx_sh   <= tx_data << shamt;
                    end else if (!cfg_hold_cs) begin
                        cs_n <= 1'b1;
                    end
                end
                XS_RUN: begin
                    if (shift_en)  tx_sh <= {tx_sh[MAX_BITS-2:0], 1'b0};
                    if (last_edge) state <= XS_TAIL;
                end
                XS_TAIL: begin
                    if (dly_done) begin
                        state <= XS_IDLE;
                        cs_n  <= !cfg_hold_cs;
                    end
                end
                default: state <= XS_IDLE;
            endcase
        end
    end

    p_accept_r9: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> (busy && !cs_n && !tx_ready));

    p_cs_busy_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> !cs_n);

    p_rx_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    p_idle_sclk_r1: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy) && !$past(rst)) |-> (sclk == $past(cfg_cpol)));

    p_release_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(cfg_hold_cs) && !$past(rst)) |-> cs_n);

endmodule

// File: tb/spi_shift_master_tb_top.sv
`timescale 1ns/1ps
module spi_shift_master_tb_top;

    localparam int CLK_DIV    = 6;
    localparam int MAX_BITS   = 16;
    localparam int SAMPLE_LAG = 2;
    localparam int HALF       = CLK_DIV / 2;
    localparam int LEN_W      = $clog2(MAX_BITS + 1);

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                cfg_cpol = 1'b0;
    logic                cfg_cpha = 1'b0;
    logic                cfg_late_sample = 1'b0;
    logic                cfg_hold_cs = 1'b0;
    logic [1:0]          cfg_delay_code = 2'b00;
    logic [LEN_W-1:0]    frame_len = LEN_W'(8);
    logic                tx_valid = 1'b0;
    logic                tx_ready;
    logic [MAX_BITS-1:0] tx_data = '0;
    logic                rx_valid;
    logic [MAX_BITS-1:0] rx_data;
    logic                busy;
    logic                sclk;
    logic                mosi;
    logic                miso = 1'b0;
    logic                cs_n;

    int total  = 0;
    int errors = 0;

    always #4 clk = ~clk;

    spi_shift_master #(
        .CLK_DIV    (CLK_DIV),
        .MAX_BITS   (MAX_BITS),
        .SAMPLE_LAG (SAMPLE_LAG)
    ) dut_i (
        .clk             (clk),
        .rst             (rst),
        .cfg_cpol        (cfg_cpol),
        .cfg_cpha        (cfg_cpha),
        .cfg_late_sample (cfg_late_sample),
        .cfg_hold_cs     (cfg_hold_cs),
        .cfg_delay_code  (cfg_delay_code),
        .frame_len       (frame_len),
        .tx_valid        (tx_valid),
        .tx_ready        (tx_ready),
        .tx_data         (tx_data),
        .rx_valid        (rx_valid),
        .rx_data         (rx_data),
        .busy            (busy),
        .sclk            (sclk),
        .mosi            (mosi),
        .miso            (miso),
        .cs_n            (cs_n)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One frame. The model peripheral drives the true bit only during the
    // SAMPLE_LAG clocks after each capture edge and the inverted bit otherwise.
    task automatic run_frame(input logic [15:0] data, input int nb, input bit cpol,
                             input bit cpha, input bit late, input bit hold,
                             input logic [1:0] code, input logic [15:0] pat,
                             input bit junk);
        int ms[16];
        int x_end, d_len, mcap, nend, vcount, bad_sclk, bad_mosi, bad_cs, bad_busy, bad_rxt;
        logic [15:0] mask, exp_rx, got_rx;
        x_end = 2 * nb * HALF;
        d_len = 2 * int'(code) + 1;
        for (int j = 0; j < nb; j++) ms[j] = HALF * ((cpha ? 2*j + 1 : 2*j) + 1);
        mcap  = ms[nb-1] + (late ? SAMPLE_LAG : 0);
        nend  = ((x_end + d_len > mcap) ? x_end + d_len : mcap) + 2;
        mask  = 16'((32'h1 << nb) - 1);
        exp_rx = late ? (pat & mask) : (~pat & mask);
        vcount = 0; bad_sclk = 0; bad_mosi = 0; bad_cs = 0; bad_busy = 0; bad_rxt = 0;
        got_rx = '0;

        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        cfg_cpol = cpol; cfg_cpha = cpha; cfg_late_sample = late;
        cfg_hold_cs = hold; cfg_delay_code = code; frame_len = LEN_W'(nb);
        tx_data = data; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = junk;
        tx_data  = junk ? ~data : data;
        for (int n = 1; n <= nend; n++) begin
            int edges;
            bit in_frame, mval, found;
            if (junk && n == x_end) tx_valid = 1'b0;
            edges = (n - 1) / HALF;
            if (edges > 2 * nb) edges = 2 * nb;
            if (sclk !== (cpol ^ edges[0])) bad_sclk++;
            for (int j = 0; j < nb; j++)
                if (n == ms[j] && mosi !== data[nb-1-j]) bad_mosi++;
            in_frame = (n <= x_end + d_len);
            if (cs_n !== (in_frame ? 1'b0 : !hold)) bad_cs++;
            if (busy !== in_frame || tx_ready !== !in_frame) bad_busy++;
            if (rx_valid === 1'b1) begin
                vcount++;
                got_rx = rx_data;
                if (n - 1 != mcap) bad_rxt++;
            end
            mval = 1'b0; found = 1'b0;
            for (int j = 0; j < nb; j++) begin
                if (!found && n <= ms[j] + SAMPLE_LAG) begin
                    found = 1'b1;
                    mval  = (n > ms[j]) ? pat[nb-1-j] : ~pat[nb-1-j];
                end
            end
            miso = mval;
            @(negedge clk);
        end
        check(bad_sclk == 0, "R1", "sclk level mismatches", bad_sclk, 0);
        check(bad_mosi == 0, cpha ? "R3" : "R2", "mosi bit mismatches", bad_mosi, 0);
        check(got_rx == exp_rx, late ? "R5 R6" : "R4 R6", "received word", got_rx, exp_rx);
        check(vcount == 1 && bad_rxt == 0, "R7", "rx_valid pulses / misplaced",
              vcount * 16 + bad_rxt, 16);
        check(bad_cs == 0, hold ? "R8 R10" : "R8", "cs_n window mismatches", bad_cs, 0);
        check(bad_busy == 0, junk ? "R9 ignored tx_valid" : "R9", "busy/ready mismatches",
              bad_busy, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        total++;
        $display("FAIL watchdog: got expired expected finish");
        $display("Result: errors=%0d of %0d checks", errors, total);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        check(cs_n === 1'b1, "R8", "cs_n after reset", cs_n, 1);
        check(busy === 1'b0 && tx_ready === 1'b1, "R9", "busy/ready after reset",
              {busy, tx_ready}, 2'b01);
        check(rx_valid === 1'b0, "R7", "rx_valid after reset", rx_valid, 0);
        check(sclk === 1'b0, "R1", "sclk idle after reset", sclk, 0);

        // classic, phase 0, idle low, 8 bits, shortest delay
        run_frame(16'h00A5, 8, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 16'h003C, 1'b0);
        // classic, phase 1, idle high, full 16 bits, longest delay, tx_valid held while busy
        run_frame(16'hC3E1, 16, 1'b1, 1'b1, 1'b0, 1'b0, 2'b11, 16'h5A96, 1'b1);
        // late sample, phase 0, idle high, shortest frame
        run_frame(16'h0009, 4, 1'b1, 1'b0, 1'b1, 1'b0, 2'b01, 16'h0006, 1'b0);
        // late sample, phase 1, idle low, 12 bits
        run_frame(16'h0B2D, 12, 1'b0, 1'b1, 1'b1, 1'b0, 2'b10, 16'h0E71, 1'b0);
        // continuous select across two frames
        run_frame(16'h0096, 8, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 16'h00F0, 1'b0);
        run_frame(16'h7F01, 15, 1'b1, 1'b1, 1'b1, 1'b1, 2'b01, 16'h2AB4, 1'b0);
        check(cs_n === 1'b0 && busy === 1'b0, "R10", "cs_n held while idle",
              {cs_n, busy}, 2'b00);
        cfg_hold_cs = 1'b0;
        @(negedge clk);
        check(cs_n === 1'b1, "R10", "cs_n after hold cleared", cs_n, 1);
        check(sclk === cfg_cpol, "R1", "sclk idle after frames", sclk, cfg_cpol);

        $display("Result: errors=%0d of %0d checks", errors, total);
        $finish;
    end

endmodule